// File: doc/BRIEF.md
# Path BIP-8 Monitor with Near-End and Far-End Error Counters

This block watches the byte stream of STS-1 synchronous payload envelopes and checks path-level parity. It folds every accepted SPE byte into an even bit-interleaved parity (BIP-8). When the next SPE begins, that total becomes the reference for the B3 byte carried inside the new SPE. Mismatched bit positions are turned into a near-end error increment and into the REI-P value returned to the far end. The G1 byte of each SPE carries a far-end error nibble, which feeds a second counter.

Two control pins pick how errors are counted. `b3_per_spe` chooses between counting every wrong parity bit and counting each errored SPE once. The same choice sets the REI-P value sent back. `rei_per_spe` chooses between adding the received nibble and adding one per SPE that reports errors. Both counters saturate. A snapshot strobe copies them out and restarts them without losing the event of that cycle. A sticky status bit with an active-low interrupt flags any parity mismatch.

The input is a valid/ready byte stream. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. The block never applies back-pressure: `in_ready` is low while reset is held and high from the first clock after reset. An upstream source may leave gaps by dropping `in_valid`. Markers and data seen in such cycles are ignored.

Top module: `path_bip8_monitor`

## Requirements
- R1: The parity of an SPE is the XOR of every accepted byte, starting with the byte marked `in_spe_start` and ending before the next accepted start byte. Bytes offered with `in_valid` low contribute nothing.
- R2: The B3 byte is compared against the parity of the previous SPE, never the SPE that carries it. This holds when the B3 byte is the start byte itself.
- R3: After reset or after a cycle with `align_lost` high, the first SPE yields no comparison: no count, no REI-P output and no status. The byte offered in an `align_lost` cycle is dropped.
- R4: With `b3_per_spe` = 0, each comparison adds to the B3 counter the number of differing bits, from 0 to 8.
- R5: With `b3_per_spe` = 1, each comparison adds 1 to the B3 counter if any bit differs, and 0 otherwise.
- R6: With `rei_per_spe` = 0, each accepted G1 byte adds its upper nibble (bits 7:4) to the REI counter when that value is 8 or less. Values 9 to 15 add nothing.
- R7: With `rei_per_spe` = 1, each accepted G1 byte adds 1 when its upper nibble is between 1 and 8, and 0 otherwise.
- R8: One cycle after a compared B3 byte is taken, `rei_tx_valid` pulses for one cycle. At the same time `rei_tx` shows the differing-bit count (0 to 8) in per-bit mode, or 0/1 in per-SPE mode. Between pulses `rei_tx` holds its value.
- R9: A comparison with any differing bit sets `b3_status` on the next clock. `status_rd` clears it, and a set in the same cycle wins over the clear. `irq_n` is low exactly when `b3_status` and `irq_en` are both high.
- R10: Both counters stop at all-ones and never wrap.
- R11: On `cnt_snap`, each snapshot output takes the counter value from before that edge. Each counter restarts from that cycle's increment alone.
- R12: `in_ready` is low during reset and high from the first clock after reset. All counters, snapshots and status bits reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | SPE byte |
| in_spe_start | input | 1 | Byte is the first of an SPE |
| in_b3_mark | input | 1 | Byte is the B3 parity byte |
| in_g1_mark | input | 1 | Byte is the G1 status byte |
| align_lost | input | 1 | Drop parity history |
| b3_per_spe | input | 1 | B3 counting mode: 1 per SPE, 0 per bit |
| rei_per_spe | input | 1 | REI counting mode: 1 per SPE, 0 nibble value |
| irq_en | input | 1 | Enable for the interrupt output |
| status_rd | input | 1 | Clear strobe for the status bit |
| cnt_snap | input | 1 | Snapshot and restart strobe for the counters |
| b3_cnt | output | CNT_W | Live B3 error count |
| rei_cnt | output | CNT_W | Live far-end error count |
| b3_snap | output | CNT_W | B3 count captured at the last snapshot |
| rei_snap | output | CNT_W | Far-end count captured at the last snapshot |
| rei_tx | output | 4 | REI-P value to send back |
| rei_tx_valid | output | 1 | Pulse marking a new `rei_tx` |
| b3_status | output | 1 | Sticky parity-error status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench places the B3 byte both at the start byte and later in the SPE. A design that compared against its own SPE, or that took the previous parity one byte late, would then count errors on clean traffic. It drives idle cycles carrying stray markers and data, pulses `align_lost` in the middle of the stream, and sends G1 nibbles above 8. These catch a design that accepts unqualified bytes, compares against stale parity, or treats an out-of-range nibble as a count. Long runs of fully inverted parity drive a narrow counter into saturation, where wrapping would show at once. Snapshot and clear strobes land on cycles that also carry an increment or a status set, which exposes any priority mistake.

// File: rtl/bip8_pkg.sv
package bip8_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int REI_MAX_ERRS = 8;

  function automatic logic [NIB_W-1:0] ones8(input logic [BYTE_W-1:0] v);
    logic [NIB_W-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      n = n + {{(NIB_W-1){1'b0}}, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/bip8_accum.sv
module bip8_accum
  import bip8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              align_lost,
  input  logic              spe_start,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] ref_par,
  output logic              ref_ok
);

  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] prev_q;
  logic              in_spe_q;
  logic              prev_ok_q;

  // The reference for a B3 byte that is itself the start byte is the
  // total still sitting in the accumulator.
  always_comb begin
    if (spe_start) begin
      ref_par = acc_q;
      ref_ok  = in_spe_q;
    end else begin
      ref_par = prev_q;
      ref_ok  = prev_ok_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      prev_q    <= '0;
      in_spe_q  <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (align_lost) begin
      in_spe_q  <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (take) begin
      if (spe_start) begin
        prev_q    <= acc_q;
        prev_ok_q <= in_spe_q;
        acc_q     <= data;
        in_spe_q  <= 1'b1;
      end else if (in_spe_q) begin
        acc_q <= acc_q ^ data;
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && spe_start && !align_lost) |=> in_spe_q); // R1
  AST_ALIGN_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    align_lost |=> (!prev_ok_q && !in_spe_q)); // R3

endmodule

// File: rtl/bip8_sat_counter.sv
module bip8_sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             snap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap_val
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    base = snap ? '0 : cnt_q;
    sum  = {1'b0, base} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    next_cnt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= next_cnt;
      if (snap) snap_q <= cnt_q;
    end
  end

  assign cnt      = cnt_q;
  assign snap_val = snap_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !snap) |=> cnt_q == CNT_MAX); // R10
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> cnt_q >= $past(cnt_q)); // R10
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> snap_q == $past(cnt_q)); // R11

endmodule

// File: rtl/bip8_sticky_irq.sv
module bip8_sticky_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic status,
  output logic irq_n
);

  logic status_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   status_q <= 1'b0;
    else if (set) status_q <= 1'b1;
    else if (clr) status_q <= 1'b0;
  end

  assign status = status_q;
  assign irq_n  = ~(status_q & en);

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> status_q); // R9
  AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr) |=> status_q); // R9

endmodule

// File: rtl/path_bip8_monitor.sv
module path_bip8_monitor
  import bip8_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_spe_start,
  input  logic             in_b3_mark,
  input  logic             in_g1_mark,
  input  logic             align_lost,
  input  logic             b3_per_spe,
  input  logic             rei_per_spe,
  input  logic             irq_en,
  input  logic             status_rd,
  input  logic             cnt_snap,
  output logic [CNT_W-1:0] b3_cnt,
  output logic [CNT_W-1:0] rei_cnt,
  output logic [CNT_W-1:0] b3_snap,
  output logic [CNT_W-1:0] rei_snap,
  output logic [3:0]       rei_tx,
  output logic             rei_tx_valid,
  output logic             b3_status,
  output logic             irq_n
);

  localparam logic [NIB_W-1:0] NIB_LIMIT = NIB_W'(REI_MAX_ERRS);

  logic              ready_q;
  logic              take;
  logic [BYTE_W-1:0] ref_par;
  logic              ref_ok;
  logic [BYTE_W-1:0] mism;
  logic [NIB_W-1:0]  nbits;
  logic              chk_fire;
  logic              any_err;
  logic [NIB_W-1:0]  b3_inc;
  logic [NIB_W-1:0]  far_nib;
  logic [NIB_W-1:0]  rei_inc;
  logic [NIB_W-1:0]  tx_val;
  logic [3:0]        tx_q;
  logic              tx_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;

  assign take = in_valid & ready_q & ~align_lost;

  bip8_accum u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .align_lost (align_lost),
    .spe_start  (in_spe_start),
    .data       (in_data),
    .ref_par    (ref_par),
    .ref_ok     (ref_ok)
  );

  always_comb begin
    mism     = in_data ^ ref_par;
    nbits    = ones8(mism);
    any_err  = |mism;
    chk_fire = take & in_b3_mark & ref_ok;
    tx_val   = b3_per_spe ? {{(NIB_W-1){1'b0}}, any_err} : nbits;
    b3_inc   = chk_fire ? tx_val : '0;
    far_nib  = in_data[7:4];
    rei_inc  = '0;
    if (take && in_g1_mark && far_nib <= NIB_LIMIT) begin
      rei_inc = rei_per_spe ? {{(NIB_W-1){1'b0}}, (far_nib != '0)} : far_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      tx_v_q <= 1'b0;
    end else begin
      tx_v_q <= chk_fire;
      if (chk_fire) tx_q <= tx_val;
    end
  end
  assign rei_tx       = tx_q;
  assign rei_tx_valid = tx_v_q;

  bip8_sat_counter #(.CNT_W(CNT_W), .INC_W(NIB_W)) u_b3_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (b3_inc),
    .snap     (cnt_snap),
    .cnt      (b3_cnt),
    .snap_val (b3_snap)
  );

  bip8_sat_counter #(.CNT_W(CNT_W), .INC_W(NIB_W)) u_rei_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (rei_inc),
    .snap     (cnt_snap),
    .cnt      (rei_cnt),
    .snap_val (rei_snap)
  );

  bip8_sticky_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (chk_fire & any_err),
    .clr    (status_rd),
    .en     (irq_en),
    .status (b3_status),
    .irq_n  (irq_n)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready); // R12
  AST_TX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rei_tx_valid |-> rei_tx <= 4'd8); // R4
  AST_TX_PER_SPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rei_tx_valid && $past(b3_per_spe)) |-> rei_tx <= 4'd1); // R5
  AST_NO_REF_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_b3_mark && !ref_ok) |=> !rei_tx_valid); // R3

endmodule

// File: tb/path_bip8_monitor_test.sv
`timescale 1ns/1ps
module path_bip8_monitor_test;

  localparam int W   = 6;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_spe_start = 0, in_b3_mark = 0, in_g1_mark = 0;
  logic [7:0] in_data = 0;
  logic align_lost = 0, b3_per_spe = 0, rei_per_spe = 0, irq_en = 1;
  logic status_rd = 0, cnt_snap = 0;
  logic in_ready, rei_tx_valid, b3_status, irq_n;
  logic [W-1:0] b3_cnt, rei_cnt, b3_snap, rei_snap;
  logic [3:0] rei_tx;

  always #4 clk = ~clk;

  path_bip8_monitor #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_spe_start(in_spe_start), .in_b3_mark(in_b3_mark),
    .in_g1_mark(in_g1_mark), .align_lost(align_lost), .b3_per_spe(b3_per_spe),
    .rei_per_spe(rei_per_spe), .irq_en(irq_en), .status_rd(status_rd),
    .cnt_snap(cnt_snap), .b3_cnt(b3_cnt), .rei_cnt(rei_cnt), .b3_snap(b3_snap),
    .rei_snap(rei_snap), .rei_tx(rei_tx), .rei_tx_valid(rei_tx_valid),
    .b3_status(b3_status), .irq_n(irq_n)
  );

  int n_chk = 0, n_fail = 0;
  bit checking = 0, done = 0;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_acc, m_prev, m_b3, m_rei, m_b3s, m_reis, m_tx;
  bit m_in_spe, m_prev_ok, m_status, m_ready, m_txv;

  function automatic int popc(int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  always @(posedge clk) begin
    int refv, incb, incr, bits, nib;
    bit refok, setb;
    incb = 0; incr = 0; setb = 0;
    if (!rst_n) begin
      m_acc = 0; m_prev = 0; m_b3 = 0; m_rei = 0; m_b3s = 0; m_reis = 0;
      m_tx = 0; m_in_spe = 0; m_prev_ok = 0; m_status = 0; m_ready = 0; m_txv = 0;
    end else begin
      m_txv = 0;
      if (align_lost) begin
        m_in_spe = 0; m_prev_ok = 0;
      end else if (in_valid && m_ready) begin
        refv  = in_spe_start ? m_acc : m_prev;
        refok = in_spe_start ? m_in_spe : m_prev_ok;
        if (in_b3_mark && refok) begin
          bits = popc(in_data ^ refv);
          incb = b3_per_spe ? (bits != 0) : bits;
          m_tx = incb; m_txv = 1; setb = (bits != 0);
        end
        if (in_g1_mark) begin
          nib = in_data >> 4;
          if (nib <= 8) incr = rei_per_spe ? (nib != 0) : nib;
        end
        if (in_spe_start) begin
          m_prev = m_acc; m_prev_ok = m_in_spe; m_acc = in_data; m_in_spe = 1;
        end else if (m_in_spe) m_acc = m_acc ^ in_data;
      end
      if (cnt_snap) begin
        m_b3s = m_b3; m_reis = m_rei; m_b3 = 0; m_rei = 0;
      end
      m_b3  = (m_b3 + incb > MAX) ? MAX : m_b3 + incb;
      m_rei = (m_rei + incr > MAX) ? MAX : m_rei + incr;
      if (setb) m_status = 1; else if (status_rd) m_status = 0;
      m_ready = 1;
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      chk("R12 in_ready", in_ready, m_ready);
      chk("R1/R2/R3/R4/R5/R10 b3_cnt", b3_cnt, m_b3);
      chk("R6/R7/R10 rei_cnt", rei_cnt, m_rei);
      chk("R11 b3_snap", b3_snap, m_b3s);
      chk("R11 rei_snap", rei_snap, m_reis);
      chk("R3/R8 rei_tx_valid", rei_tx_valid, m_txv);
      if (m_txv) chk("R8 rei_tx", rei_tx, m_tx);
      chk("R9 b3_status", b3_status, m_status);
      chk("R9 irq_n", irq_n, !(m_status && irq_en));
    end
  end

  // Stimulus
  int gen_prev = 0;
  bit rnd_strobes = 0;

  task automatic drive_idle();
    @(negedge clk); #1;
    in_valid = 0; in_data = 8'($urandom);
    in_spe_start = 1'($urandom); in_b3_mark = 1'($urandom); in_g1_mark = 1'($urandom);
    status_rd = rnd_strobes && ($urandom % 6 == 0);
    cnt_snap  = rnd_strobes && ($urandom % 9 == 0);
  endtask

  task automatic send_spe(int len, int b3pos, int g1pos, int mask, int nib, int gap);
    int bytes[64];
    int x = 0;
    for (int k = 0; k < len; k++) bytes[k] = $urandom % 256;
    bytes[g1pos] = (nib << 4) | (bytes[g1pos] & 15);
    bytes[b3pos] = (gen_prev ^ mask) & 255;
    for (int k = 0; k < len; k++) x ^= bytes[k];
    gen_prev = x;
    for (int k = 0; k < len; k++) begin
      if (gap != 0 && ($urandom % gap == 0)) drive_idle();
      @(negedge clk); #1;
      in_valid = 1; in_data = 8'(bytes[k]);
      in_spe_start = (k == 0); in_b3_mark = (k == b3pos); in_g1_mark = (k == g1pos);
      status_rd = rnd_strobes && ($urandom % 6 == 0);
      cnt_snap  = rnd_strobes && ($urandom % 9 == 0);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    checking = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    // R3: first SPE has no reference, even with a bad B3
    send_spe(12, 2, 3, 8'hFF, 0, 0);
    @(negedge clk); chk("R3 first SPE not compared", b3_cnt, 0);
    // R4 per-bit mode with gaps (R1)
    b3_per_spe = 0;
    send_spe(12, 2, 3, 8'h00, 0, 3);
    send_spe(15, 2, 3, 8'h81, 2, 3);
    send_spe(10, 2, 3, 8'h07, 9, 3);
    send_spe(10, 2, 3, 8'h00, 15, 0);
    // R2: B3 carried in the start byte
    send_spe(9, 0, 4, 8'h10, 8, 2);
    send_spe(9, 0, 4, 8'h00, 1, 2);
    // R5 / R7 per-SPE modes
    b3_per_spe = 1; rei_per_spe = 1;
    send_spe(11, 1, 5, 8'h3C, 5, 0);
    send_spe(11, 1, 5, 8'h00, 0, 3);
    send_spe(11, 1, 5, 8'h01, 12, 3);
    // R3: alignment lost mid-stream
    @(negedge clk); #1; in_valid = 1; align_lost = 1;
    @(negedge clk); #1; align_lost = 0; in_valid = 0;
    send_spe(10, 3, 4, 8'hAA, 3, 0);
    send_spe(10, 3, 4, 8'h55, 3, 0);
    // R9 / R11 strobes colliding with updates
    rnd_strobes = 1; b3_per_spe = 0; rei_per_spe = 0;
    for (int s = 0; s < 20; s++) send_spe(8 + s % 5, s % 3, 4, $urandom % 256, $urandom % 16, 4);
    irq_en = 0;
    send_spe(10, 2, 3, 8'h0F, 4, 0);
    irq_en = 1;
    rnd_strobes = 0;
    status_rd = 0; cnt_snap = 0;
    // R10 saturation
    for (int s = 0; s < 12; s++) send_spe(8, 1, 2, 8'hFF, 8, 0);
    @(negedge clk); #1; in_valid = 0;
    @(negedge clk);
    chk("R10 b3 saturated", b3_cnt, MAX);
    chk("R10 rei saturated", rei_cnt, MAX);
    // R11 snapshot at saturation
    #1; cnt_snap = 1;
    @(negedge clk); #1; cnt_snap = 0;
    @(negedge clk);
    chk("R11 snap holds old count", b3_snap, MAX);
    chk("R11 counter restarted", b3_cnt, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule